// File: doc/BRIEF.md
# Split Divide-by-Two and Divide-by-Eight Counter

This block is a four-bit counter made of two independent sections that share a clear. The low section is a single toggle stage, bit 0, with its own count strobe. The high section is a three-bit binary counter, bits 3 to 1, with a separate count strobe. Neither section is wired to the other inside the block. All four bits clear when both master-reset inputs are high at a clock edge.

Everything runs on one system clock. Each section's count input is a single-cycle enable strobe sampled at the rising edge. The modulus is set outside the block. Driving the high strobe with the low strobe gated by bit 0 gives a sixteen-state counter.

Routing the bits that are high at a terminal count X back to the two reset inputs gives a truncated MOD-X count. The state X then lasts exactly one clock before the counter returns to zero. A terminal count above 15, or one that has more than two high bits, needs gating outside the block.

Top module: `split_counter`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, all four bits of `q` are 0 after that edge.
- R2: With no clear, a high `cnt_lo` at an edge inverts `q[0]`; a low `cnt_lo` leaves `q[0]` unchanged.
- R3: With no clear, a high `cnt_hi` at an edge adds one to `q[3:1]` modulo 8, so 7 wraps to 0; a low `cnt_hi` leaves `q[3:1]` unchanged.
- R4: The sections are independent: `cnt_hi` never changes `q[0]`, `cnt_lo` never changes `q[3:1]`, and the value of `q[0]` has no effect on the high section.
- R5: When `mr_a` and `mr_b` are both high at an edge, `q` is 0 after that edge; either one alone has no effect.
- R6: The clear from R5 overrides both count strobes in the same cycle.
- R7: With `cnt_hi = cnt_lo & q[0]` and a strobe on every cycle, `q` steps 0,1,...,15,0.
- R8: With `mr_a = q[1]`, `mr_b = q[2]` and the chaining from R7, `q` steps 0 to 5 on strobes, then shows 6 for exactly one cycle, then shows 0, whether or not a strobe arrives in that cycle.
- R9: With `mr_a = q[1]`, `mr_b = q[3]` and the chaining from R7, `q` steps 0 to 9, shows 10 for one cycle, then returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cnt_lo | input | 1 | Count strobe for the bit-0 toggle stage |
| cnt_hi | input | 1 | Count strobe for the three-bit stage |
| mr_a | input | 1 | Master reset, first input of the AND-combined clear |
| mr_b | input | 1 | Master reset, second input of the AND-combined clear |
| q | output | 4 | Counter state; bit 0 is the toggle stage, bits 3..1 the binary stage |

## Verification
The counter state appears directly on `q`, so a wrong next-state value shows up one cycle after the edge that caused it. A fault in the clear combiner shows up as a count that survives when both resets are high, or as a clear when only one is high. A fault in the feedback moduli shows up as a skipped, repeated or lingering terminal state. With every strobe, reset and state combination swept, it can show up within a single period of the chosen modulus.

// File: rtl/split_counter_pkg.sv
package split_counter_pkg;

    localparam int LO_W    = 1;
    localparam int HI_W    = 3;
    localparam int TOTAL_W = LO_W + HI_W;
    localparam int MR_N    = 2;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic            lo;
    } cnt_s;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_COUNT = 2'd1,
        ACT_CLEAR = 2'd2
    } stage_act_e;

    function automatic stage_act_e pick_act(input logic clr, input logic en);
        if (clr)
            return ACT_CLEAR;
        else if (en)
            return ACT_COUNT;
        else
            return ACT_HOLD;
    endfunction

    function automatic logic [HI_W-1:0] inc_wrap(input logic [HI_W-1:0] v);
        return v + {{(HI_W-1){1'b0}}, 1'b1};
    endfunction

endpackage

// File: rtl/sc_clear_combine.sv
module sc_clear_combine #(
    parameter int MR_N = 2
) (
    input  logic [MR_N-1:0] mr,
    output logic            clr
);

    logic [MR_N:0] chain;

    assign chain[0] = 1'b1;

    genvar gi;
    generate
        for (gi = 0; gi < MR_N; gi++) begin : g_and
            assign chain[gi+1] = chain[gi] & mr[gi];
        end
    endgenerate

    assign clr = chain[MR_N];

    always_comb begin
        if (!$isunknown(mr) && (mr != {MR_N{1'b1}}))
            AST_PARTIAL_MR_NO_CLEAR: assert (!clr); // R5
    end

endmodule

// File: rtl/sc_toggle_stage.sv
module sc_toggle_stage
    import split_counter_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic q
);

    stage_act_e act;

    always_comb act = pick_act(clr, en);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            unique case (act)
                ACT_CLEAR: q <= 1'b0;
                ACT_COUNT: q <= ~q;
                default:   q <= q;
            endcase
        end
    end

    AST_LO_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (!clr && en) |=> (q != $past(q))); // R2

    AST_LO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clr && !en) |=> $stable(q)); // R2

endmodule

// File: rtl/sc_binary_stage.sv
module sc_binary_stage
    import split_counter_pkg::*;
#(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] TOP_VAL = {W{1'b1}};

    stage_act_e   act;
    logic [W-1:0] q_next;

    always_comb begin
        act    = pick_act(clr, en);
        q_next = q;
        unique case (act)
            ACT_CLEAR: q_next = '0;
            ACT_COUNT: q_next = q + {{(W-1){1'b0}}, 1'b1};
            default:   q_next = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= q_next;
    end

    AST_HI_STEP: assert property (@(posedge clk) disable iff (rst)
        (!clr && en) |=> (q == W'($past(q) + 1'b1))); // R3

    AST_HI_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!clr && en && q == TOP_VAL) |=> (q == '0)); // R3

    AST_HI_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clr && !en) |=> $stable(q)); // R3

endmodule

// File: rtl/split_counter.sv
module split_counter
    import split_counter_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cnt_lo,
    input  logic               cnt_hi,
    input  logic               mr_a,
    input  logic               mr_b,
    output logic [TOTAL_W-1:0] q
);

    logic  clr;
    cnt_s  st;

    sc_clear_combine #(.MR_N(MR_N)) u_clr (
        .mr  ({mr_b, mr_a}),
        .clr (clr)
    );

    sc_toggle_stage u_lo (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .en  (cnt_lo),
        .q   (st.lo)
    );

    sc_binary_stage #(.W(HI_W)) u_hi (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .en  (cnt_hi),
        .q   (st.hi)
    );

    assign q = st;

    AST_RST_ZERO: assert property (@(posedge clk)
        rst |=> (q == '0)); // R1

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mr_a && mr_b) |=> (q == '0)); // R5

    AST_CLEAR_OVER_COUNT: assert property (@(posedge clk) disable iff (rst)
        (mr_a && mr_b && (cnt_lo || cnt_hi)) |=> (q == '0)); // R6

    AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (rst)
        (!mr_a || !mr_b) && !cnt_lo |=> (q[0] == $past(q[0]))); // R4

    AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
        (!mr_a || !mr_b) && !cnt_hi |=> (q[TOTAL_W-1:1] == $past(q[TOTAL_W-1:1]))); // R4

endmodule

// File: tb/split_counter_tb.sv
module split_counter_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       d_lo = 1'b0, d_hi = 1'b0, d_ma = 1'b0, d_mb = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       cnt_lo, cnt_hi, mr_a, mr_b;
    logic [3:0] q;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // mode 0: direct drive; 1: chained sixteen; 2: truncated six; 3: truncated ten
    always_comb begin
        cnt_lo = d_lo;
        cnt_hi = (mode == 2'd0) ? d_hi : (d_lo & q[0]);
        case (mode)
            2'd2:    begin mr_a = q[1]; mr_b = q[2]; end
            2'd3:    begin mr_a = q[1]; mr_b = q[3]; end
            default: begin mr_a = d_ma; mr_b = d_mb; end
        endcase
    end

    split_counter u_dut (
        .clk    (clk),
        .rst    (rst),
        .cnt_lo (cnt_lo),
        .cnt_hi (cnt_hi),
        .mr_a   (mr_a),
        .mr_b   (mr_b),
        .q      (q)
    );

    task automatic check(input string tag, input logic [3:0] exp);
        checks++;
        if (q !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, q, exp);
        end
    endtask

    // inputs set at a falling edge, result sampled at the next falling edge
    task automatic step(input logic lo, input logic hi, input logic ma, input logic mb);
        d_lo = lo; d_hi = hi; d_ma = ma; d_mb = mb;
        @(negedge clk);
    endtask

    task automatic reach(input int s);
        step(1'b0, 1'b0, 1'b1, 1'b1);
        for (int k = 0; k < (s >> 1); k++) step(1'b0, 1'b1, 1'b0, 1'b0);
        if (s[0]) step(1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic run_chain(input logic [1:0] m, input int fa, input int fb,
                             input int cycles, input int gap, input string tag);
        logic [3:0] e = 4'd0;
        logic       s;
        logic       hit;
        mode = 2'd0;
        step(1'b0, 1'b0, 1'b1, 1'b1);
        mode = m;
        for (int c = 0; c < cycles; c++) begin
            s   = ((c % gap) == 0);
            hit = (m != 2'd1) && e[fa] && e[fb];
            step(s, 1'b0, 1'b0, 1'b0);
            if (hit)    e = 4'd0;
            else if (s) e = e + 4'd1;
            check(tag, e);
        end
        step(1'b0, 1'b0, 1'b0, 1'b0);
        mode = 2'd0;
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1", 4'd0);
        // reset overrides strobes and a nonzero state
        rst = 1'b0;
        step(1'b1, 1'b1, 1'b0, 1'b0);
        rst = 1'b1;
        step(1'b1, 1'b1, 1'b0, 1'b0);
        check("R1", 4'd0);
        rst = 1'b0;

        // exhaustive sweep: every state, strobe pair and reset pair
        for (int s = 0; s < 16; s++) begin
            for (int v = 0; v < 16; v++) begin
                logic       lo = v[0], hi = v[1], ma = v[2], mb = v[3];
                logic [3:0] e;
                string      tag;
                reach(s);
                check("R3", 4'(s));
                if (ma && mb) begin
                    e   = 4'd0;
                    tag = (lo || hi) ? "R6" : "R5";
                end else begin
                    e[0]   = s[0] ^ lo;
                    e[3:1] = 3'((s >> 1) + (hi ? 1 : 0));
                    if (ma || mb)      tag = "R5";
                    else if (lo && hi) tag = "R4";
                    else if (hi)       tag = "R3";
                    else               tag = "R2";
                end
                step(lo, hi, ma, mb);
                check(tag, e);
            end
        end

        run_chain(2'd1, 0, 0, 40, 1, "R7");
        run_chain(2'd2, 1, 2, 30, 1, "R8");
        run_chain(2'd2, 1, 2, 40, 2, "R8");
        run_chain(2'd3, 1, 3, 45, 1, "R9");
        run_chain(2'd3, 1, 3, 50, 3, "R9");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule